// File: doc/BRIEF.md
# Configurable I2S Serial Transmitter

This block turns parallel audio samples into a serial audio stream with three lines: a bit clock, a word select line that marks the channel, and one data line. Samples arrive through a valid/ready input and are held in a one-entry holding register. Each sample is shifted out most significant bit first. The word size can be set anywhere from 8 to 32 bits. A word select level of 0 marks the left channel and a level of 1 marks the right channel.

As master, the block divides its own system clock to make the bit clock and the word select line, and it drives both. As slave, it samples an external bit clock and word select through synchronizers. It then shifts data on the falling edges it detects and leaves the clock outputs undriven. A control bit chooses whether the left or the right channel is sent first after enable. If no sample is waiting when a channel slot starts, the slot carries zeros and a sticky flag is raised.

Top module: `i2sTx`

## Requirements
- R1: `cfgWordLen` holds the word size minus one. Values 7 to 31 give 8 to 32 bits, and smaller values are treated as 7. The word is taken from the low bits of `inData`, any bits above the word size are ignored, and the word is sent MSB first.
- R2: The MSB of a word is driven one bit-clock cycle after word select changes level. The LSB of the previous word is driven on the same falling edge as that change, so with `cfgFramePer` equal to `cfgWordLen` the words follow each other with no gap.
- R3: In master mode, `sdOut` and `wsOut` change only on a falling edge of `sckOut`. A receiver samples them on the rising edge.
- R4: In master mode, one `sckOut` period lasts 2×(`cfgClkDiv`+1) system clocks. `wsOut` toggles every `cfgFramePer`+1 bit-clock cycles. When `cfgFramePer` exceeds `cfgWordLen`, the extra bits of each slot are zero.
- R5: With `cfgMaster`=0, bit timing and channel slots follow `sckIn` and `wsIn`. `sckOe` is 0, and `sckOut` and `wsOut` stay low.
- R6: With `cfgRightFirst`=0, the first sent word occupies a left slot (word select 0). With `cfgRightFirst`=1, it occupies a right slot (word select 1). Later words alternate channels. This holds in both modes.
- R7: A word is accepted on a clock edge where `inValid` and `inReady` are both high. `inReady` is high only while the block is enabled and the holding register is empty.
- R8: A slot that starts with the holding register empty carries all zeros and sets `underflow`. `underflow` stays set, through disable as well, until `underflowClr` is pulsed.
- R9: While `cfgEnable` is 0, `sdOut`, `wsOut` and `sckOut` are low and `inReady` is low. A word waiting in the holding register is discarded, so `inReady` is high again right after re-enable.
- R10: After reset, `sdOut`, `wsOut`, `sckOut`, `inReady` and `underflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Run enable; 0 returns the block to idle |
| cfgMaster | input | 1 | 1 = generate bit clock and word select, 0 = follow external lines |
| cfgRightFirst | input | 1 | 1 = first word goes in a right slot, 0 = left slot |
| cfgWordLen | input | LEN_W (5) | Word size minus one |
| cfgFramePer | input | PER_W (6) | Bit-clock cycles per word select half-period, minus one |
| cfgClkDiv | input | DIV_W (8) | Bit clock half-period in system clocks, minus one |
| underflowClr | input | 1 | Clears the underflow flag |
| inData | input | DATA_W (32) | Sample word, right-justified |
| inValid | input | 1 | Sample word present |
| inReady | output | 1 | Holding register can accept a word |
| sckIn | input | 1 | External bit clock (slave mode) |
| wsIn | input | 1 | External word select (slave mode) |
| sckOut | output | 1 | Generated bit clock (master mode) |
| wsOut | output | 1 | Generated word select (master mode) |
| sckOe | output | 1 | Drive enable for sckOut and wsOut |
| sdOut | output | 1 | Serial data |
| underflow | output | 1 | Sticky flag: a slot started with no word |

## Verification
A wrong bit counter, word alignment or load timing shifts every later word by whole bits. This shows up in the first received slot, one word select half-period after enable. A wrong load-arming flag swaps MSB and LSB positions, or moves words by one slot, so the channel of the first word changes within two slots. A holding register that fails to clear on disable shows up at once: `inReady` stays low for the first cycles after re-enable, and the stale word appears in the next slot. A divider or word-select period error changes the measured bit-clock period or the number of bits between word select edges within the first frame.

// File: rtl/i2sTxPkg.sv
`timescale 1ns/1ps
package i2sTxPkg;
  // Strobes from bit timing control to the shift datapath
  typedef struct packed {
    logic load;   // falling edge that starts a new word (MSB out)
    logic shift;  // falling edge that advances to the next bit
    logic clear;  // block idle: flush holding and shift state
  } txStrobe_t;
endpackage

// File: rtl/i2sTxCtrl.sv
`timescale 1ns/1ps
module i2sTxCtrl
  import i2sTxPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             master,
  input  logic             rightFirst,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [PER_W-1:0] framePer,
  input  logic             sckIn,
  input  logic             wsIn,
  output txStrobe_t        strobe,
  output logic             sckOut,
  output logic             wsOut,
  output logic             sckOe
);

  logic [1:0]       sckSync, wsSync;
  logic             sckSeen, wsSeen;
  logic             modeQ;
  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] perCnt;
  logic             sckInt, wsInt;
  logic             started, armed;

  logic active, divHit, fallM, fallS, fallEv, wsChg, wsNow;

  always_comb begin
    active = enable && (modeQ == master);
    divHit = (divCnt == clkDiv);
    fallM  = master && sckInt && divHit;
    fallS  = !master && sckSeen && !sckSync[1];
    fallEv = active && (fallM || fallS);
    wsNow  = wsSync[1];
    wsChg  = (wsNow != wsSeen);
    strobe.load  = fallEv && started && armed;
    strobe.shift = fallEv && started && !armed;
    strobe.clear = !active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      wsSync  <= '0;
      sckSeen <= 1'b0;
      wsSeen  <= 1'b0;
      modeQ   <= 1'b0;
      divCnt  <= '0;
      perCnt  <= '0;
      sckInt  <= 1'b0;
      wsInt   <= 1'b0;
      started <= 1'b0;
      armed   <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      wsSync  <= {wsSync[0], wsIn};
      modeQ   <= master;
      if (!active) begin
        divCnt  <= '0;
        perCnt  <= '0;
        sckInt  <= 1'b0;
        wsInt   <= 1'b0;
        started <= 1'b0;
        armed   <= 1'b0;
        sckSeen <= sckSync[1];
        wsSeen  <= wsSync[1];
      end else begin
        sckSeen <= sckSync[1];
        if (master) begin
          if (divHit) begin
            divCnt <= '0;
            sckInt <= ~sckInt;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        if (fallEv) begin
          if (master) begin
            if (!started) begin
              started <= 1'b1;
              armed   <= 1'b1;
              wsInt   <= rightFirst;
              perCnt  <= '0;
            end else if (perCnt == framePer) begin
              perCnt <= '0;
              wsInt  <= ~wsInt;
              armed  <= 1'b1;
            end else begin
              perCnt <= perCnt + 1'b1;
              armed  <= 1'b0;
            end
          end else begin
            wsSeen <= wsNow;
            if (!started) begin
              if (wsChg && (wsNow == rightFirst)) begin
                started <= 1'b1;
                armed   <= 1'b1;
              end
            end else begin
              armed <= wsChg;
            end
          end
        end
      end
    end
  end

  assign sckOut = sckInt;
  assign wsOut  = wsInt;
  assign sckOe  = active && master;

endmodule

// File: rtl/i2sTxPath.sv
`timescale 1ns/1ps
module i2sTxPath
  import i2sTxPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 8,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              underflowClr,
  output logic              sdOut,
  output logic              underflow
);

  localparam logic [LEN_W-1:0] TOP_BIT = LEN_W'(DATA_W - 1);
  localparam logic [LEN_W-1:0] MIN_IDX = LEN_W'(MIN_LEN - 1);

  logic [DATA_W-1:0] holdQ, shReg, aligned;
  logic              holdFull;
  logic [LEN_W-1:0]  lenEff, shiftAmt;

  always_comb begin
    lenEff   = (wordLen < MIN_IDX) ? MIN_IDX : wordLen;
    shiftAmt = TOP_BIT - lenEff;
    aligned  = holdQ << shiftAmt;
    inReady  = !strobe.clear && !holdFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ    <= '0;
      holdFull <= 1'b0;
      shReg    <= '0;
    end else if (strobe.clear) begin
      holdFull <= 1'b0;
      shReg    <= '0;
    end else begin
      if (strobe.load) begin
        shReg    <= holdFull ? aligned : '0;
        holdFull <= 1'b0;
      end else if (strobe.shift) begin
        shReg <= shReg << 1;
      end
      if (inValid && inReady) begin
        holdQ    <= inData;
        holdFull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underflow <= 1'b0;
    end else if (strobe.load && !holdFull) begin
      underflow <= 1'b1;
    end else if (underflowClr) begin
      underflow <= 1'b0;
    end
  end

  assign sdOut = shReg[DATA_W-1];

endmodule

// File: rtl/i2sTx.sv
`timescale 1ns/1ps
module i2sTx
  import i2sTxPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 8,
  parameter int PER_W   = 6,
  parameter int MIN_LEN = 8,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgMaster,
  input  logic              cfgRightFirst,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic [PER_W-1:0]  cfgFramePer,
  input  logic [DIV_W-1:0]  cfgClkDiv,
  input  logic              underflowClr,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              sckIn,
  input  logic              wsIn,
  output logic              sckOut,
  output logic              wsOut,
  output logic              sckOe,
  output logic              sdOut,
  output logic              underflow
);

  txStrobe_t strobe;

  i2sTxCtrl #(.DIV_W(DIV_W), .PER_W(PER_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (cfgEnable),
    .master     (cfgMaster),
    .rightFirst (cfgRightFirst),
    .clkDiv     (cfgClkDiv),
    .framePer   (cfgFramePer),
    .sckIn      (sckIn),
    .wsIn       (wsIn),
    .strobe     (strobe),
    .sckOut     (sckOut),
    .wsOut      (wsOut),
    .sckOe      (sckOe)
  );

  i2sTxPath #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) path_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wordLen      (cfgWordLen),
    .inData       (inData),
    .inValid      (inValid),
    .inReady      (inReady),
    .underflowClr (underflowClr),
    .sdOut        (sdOut),
    .underflow    (underflow)
  );

endmodule

// File: rtl/i2sTxChecker.sv
`timescale 1ns/1ps
module i2sTxChecker (
  input logic clk,
  input logic rstN,
  input logic cfgEnable,
  input logic cfgMaster,
  input logic underflowClr,
  input logic inValid,
  input logic inReady,
  input logic sckOut,
  input logic wsOut,
  input logic sckOe,
  input logic sdOut,
  input logic underflow
);

  // R7
  hold_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!sdOut && !wsOut && !sckOut));

  // R5
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMaster |=> (!sckOut && !wsOut && !sckOe));

  // R3
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgMaster && $past(cfgEnable && cfgMaster) && !$stable(sdOut))
      |-> $fell(sckOut));

  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cfgMaster && $past(cfgEnable && cfgMaster) && !$stable(wsOut))
      |-> $fell(sckOut));

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !underflowClr) |=> underflow);

endmodule

bind i2sTx i2sTxChecker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cfgEnable    (cfgEnable),
  .cfgMaster    (cfgMaster),
  .underflowClr (underflowClr),
  .inValid      (inValid),
  .inReady      (inReady),
  .sckOut       (sckOut),
  .wsOut        (wsOut),
  .sckOe        (sckOe),
  .sdOut        (sdOut),
  .underflow    (underflow)
);

// File: tb/i2sTx_tb_top.sv
`timescale 1ns/1ps
module i2sTx_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic        cfgEnable, cfgMaster, cfgRightFirst, underflowClr;
  logic [4:0]  cfgWordLen;
  logic [5:0]  cfgFramePer;
  logic [7:0]  cfgClkDiv;
  logic [31:0] inData;
  logic        inValid, inReady;
  logic        sckIn, wsIn, sckOut, wsOut, sckOe, sdOut, underflow;

  i2sTx dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMaster(cfgMaster),
    .cfgRightFirst(cfgRightFirst), .cfgWordLen(cfgWordLen),
    .cfgFramePer(cfgFramePer), .cfgClkDiv(cfgClkDiv),
    .underflowClr(underflowClr), .inData(inData), .inValid(inValid),
    .inReady(inReady), .sckIn(sckIn), .wsIn(wsIn), .sckOut(sckOut),
    .wsOut(wsOut), .sckOe(sckOe), .sdOut(sdOut), .underflow(underflow)
  );

  int passCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    if (act === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- word source
  logic [31:0] txWords [0:255];
  int txLimit = 0;
  int txTaken = 0;
  assign inValid = (txTaken != txLimit);
  assign inData  = txWords[txTaken[7:0]];
  always @(posedge clk) if (inValid && inReady) txTaken <= txTaken + 1;

  task automatic push(input logic [31:0] w);
    txWords[txLimit[7:0]] = w;
    txLimit = txLimit + 1;
  endtask

  // ---- serial receiver model (samples on rising bit clock)
  logic        prevSck = 1'b0, prevWs = 1'b0, prevSd = 1'b0;
  logic [63:0] acc = '0;
  int          nb = 0;
  int          rxCount = 0;
  logic [63:0] rxVal [0:255];
  logic        rxCh  [0:255];
  int          phaseErr = 0;
  int          lastRise = 0;
  int          risePer = 0;

  always @(negedge clk) begin
    logic s, w;
    int   pl;
    s  = cfgMaster ? sckOut : sckIn;
    w  = cfgMaster ? wsOut : wsIn;
    pl = int'(cfgFramePer) + 1;
    if (!cfgEnable) begin
      prevSck = 1'b0; prevWs = 1'b0; acc = '0; nb = 0;
    end else begin
      if (cfgMaster && (sdOut !== prevSd) && !(prevSck && !s)) phaseErr++;
      if (s && !prevSck) begin
        risePer  = cyc - lastRise;
        lastRise = cyc;
        acc = {acc[62:0], sdOut};
        nb++;
        if (w != prevWs) begin
          if (nb >= pl) begin
            rxVal[rxCount[7:0]] = acc & ((64'd1 << pl) - 64'd1);
            rxCh[rxCount[7:0]]  = prevWs;
            rxCount++;
          end
          acc = '0;
          nb  = 0;
        end
        prevWs = w;
      end
      prevSck = s;
    end
    prevSd = sdOut;
  end

  // ---- helpers
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic goIdle();
    cfgEnable = 1'b0;
    underflowClr = 1'b1;
    tick(1);
    underflowClr = 1'b0;
    tick(3);
  endtask

  task automatic waitSlots(input int target, input string req);
    int t = 0;
    while (rxCount < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
    #1;
    check(req, "slot count reached", 64'(rxCount >= target), 64'd1);
  endtask

  function automatic logic [63:0] expSlot(input logic [31:0] w, input int len,
                                          input int per);
    logic [63:0] m;
    m = (64'd1 << (len + 1)) - 64'd1;
    return (64'(w) & m) << (per - len);
  endfunction

  task automatic slaveClock(input int perLen, input logic firstLvl,
                            input int nSlots, input int half);
    for (int p = 0; p < 2; p++) begin
      sckIn = 1'b0; tick(half); sckIn = 1'b1; tick(half);
    end
    for (int s = 0; s <= nSlots; s++) begin
      for (int b = 0; b < perLen; b++) begin
        sckIn = 1'b0;
        if (b == 0) wsIn = firstLvl ^ s[0];
        tick(half);
        sckIn = 1'b1;
        tick(half);
      end
    end
    sckIn = 1'b0;
  endtask

  // ---- scenarios
  task automatic testReset();
    check("R10", "sdOut after reset", 64'(sdOut), 64'd0);
    check("R10", "wsOut after reset", 64'(wsOut), 64'd0);
    check("R10", "sckOut after reset", 64'(sckOut), 64'd0);
    check("R10", "inReady after reset", 64'(inReady), 64'd0);
    check("R10", "underflow after reset", 64'(underflow), 64'd0);
  endtask

  task automatic masterCase(input string req, input int len, input int per,
                            input int div, input logic rf, input int n,
                            input logic [31:0] seed);
    int base, pe0;
    logic [31:0] w;
    goIdle();
    cfgMaster = 1'b1; cfgRightFirst = rf;
    cfgWordLen = 5'(len); cfgFramePer = 6'(per); cfgClkDiv = 8'(div);
    base = rxCount; pe0 = phaseErr;
    for (int i = 0; i < n; i++) push(seed ^ (32'(i) * 32'h9E3779B9));
    cfgEnable = 1'b1;
    waitSlots(base + n, req);
    for (int i = 0; i < n; i++) begin
      w = seed ^ (32'(i) * 32'h9E3779B9);
      // R1 R2 R4: word value, order and alignment within slot
      check(req, $sformatf("slot %0d value", i), rxVal[(base + i) % 256],
            expSlot(w, len, per));
      // R6: channel of each slot
      check("R6", $sformatf("slot %0d channel", i),
            64'(rxCh[(base + i) % 256]), 64'(rf ^ i[0]));
    end
    check("R4", "bit clock period", 64'(risePer), 64'(2 * (div + 1)));
    check("R3", "data changes only on falling bit clock", 64'(phaseErr - pe0), 64'd0);
    cfgEnable = 1'b0;
    tick(2);
    check("R9", "idle lines low", 64'({sdOut, wsOut, sckOut, inReady}), 64'd0);
  endtask

  task automatic testUnderflow();
    int base;
    goIdle();
    cfgMaster = 1'b1; cfgRightFirst = 1'b0;
    cfgWordLen = 5'd15; cfgFramePer = 6'd15; cfgClkDiv = 8'd1;
    base = rxCount;
    push(32'h0000_A5C3);
    cfgEnable = 1'b1;
    waitSlots(base + 3, "R8");
    check("R8", "slot with word", rxVal[base % 256], 64'h0000_A5C3);
    check("R8", "empty slot 1 zeros", rxVal[(base + 1) % 256], 64'd0);
    check("R8", "empty slot 2 zeros", rxVal[(base + 2) % 256], 64'd0);
    check("R8", "flag set", 64'(underflow), 64'd1);
    cfgEnable = 1'b0;
    tick(3);
    check("R8", "flag sticky while idle", 64'(underflow), 64'd1);
    underflowClr = 1'b1; tick(1); underflowClr = 1'b0; tick(1);
    check("R8", "flag cleared", 64'(underflow), 64'd0);
  endtask

  task automatic testSlaveDiscard();
    int base, t0;
    goIdle();
    cfgMaster = 1'b0; cfgRightFirst = 1'b0;
    cfgWordLen = 5'd15; cfgFramePer = 6'd15; cfgClkDiv = 8'd0;
    wsIn = 1'b1; sckIn = 1'b0;
    t0 = txTaken;
    push(32'h0000_DEAD);
    push(32'h0000_1234);
    tick(3);
    check("R7", "no accept while disabled", 64'(txTaken - t0), 64'd0);
    check("R9", "ready low while disabled", 64'(inReady), 64'd0);
    cfgEnable = 1'b1;
    tick(4);
    check("R7", "one word accepted", 64'(txTaken - t0), 64'd1);
    check("R7", "ready low with holding full", 64'(inReady), 64'd0);
    check("R5", "slave drives no clock lines", 64'({sckOe, sckOut, wsOut}), 64'd0);
    cfgEnable = 1'b0;
    tick(3);
    check("R9", "pending word not replaced while idle", 64'(txTaken - t0), 64'd1);
    cfgEnable = 1'b1;
    tick(3);
    check("R9", "holding emptied by disable", 64'(txTaken - t0), 64'd2);
    push(32'h0000_BEEF);
    base = rxCount;
    slaveClock(16, 1'b0, 2, 6);
    waitSlots(base + 2, "R5");
    check("R9", "discarded word absent, next word sent", rxVal[base % 256], 64'h0000_1234);
    check("R6", "slave first slot left", 64'(rxCh[base % 256]), 64'd0);
    check("R5", "slave second word", rxVal[(base + 1) % 256], 64'h0000_BEEF);
    check("R5", "slave second slot right", 64'(rxCh[(base + 1) % 256]), 64'd1);
    cfgEnable = 1'b0;
    tick(2);
  endtask

  task automatic testSlaveRight();
    int base;
    goIdle();
    cfgMaster = 1'b0; cfgRightFirst = 1'b1;
    cfgWordLen = 5'd7; cfgFramePer = 6'd7;
    wsIn = 1'b0; sckIn = 1'b0;
    push(32'hFFFF_FF96);
    push(32'h0000_0041);
    cfgEnable = 1'b1;
    tick(3);
    base = rxCount;
    slaveClock(8, 1'b1, 2, 4);
    waitSlots(base + 2, "R6");
    check("R1", "slave 8-bit word, high bits ignored", rxVal[base % 256], 64'h96);
    check("R6", "slave right first", 64'(rxCh[base % 256]), 64'd1);
    check("R2", "slave back-to-back word", rxVal[(base + 1) % 256], 64'h41);
    check("R6", "slave then left", 64'(rxCh[(base + 1) % 256]), 64'd0);
    cfgEnable = 1'b0;
    tick(2);
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0;
    cfgEnable = 1'b0; cfgMaster = 1'b0; cfgRightFirst = 1'b0;
    underflowClr = 1'b0; cfgWordLen = 5'd7; cfgFramePer = 6'd7; cfgClkDiv = 8'd0;
    sckIn = 1'b0; wsIn = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(2);
    testReset();
    masterCase("R1", 15, 15, 1, 1'b0, 4, 32'h0000_C3A5);
    masterCase("R1", 7, 7, 2, 1'b1, 4, 32'hABCD_EF5A);
    masterCase("R2", 31, 31, 0, 1'b0, 3, 32'h8123_4567);
    masterCase("R4", 7, 9, 1, 1'b0, 3, 32'h0000_00B1);
    testUnderflow();
    testSlaveDiscard();
    testSlaveRight();
    finish();
  end

endmodule